// File: doc/BRIEF.md
# Power Policy Engine Controller

This block keeps four power policies (0 to 3, a lower number using less power) and one 32-bit clock enable mask per policy. It runs a small engine that moves a requested target policy into the active policy. The active policy number and the enable mask of that policy leave the block as ports. Software drives it through a word-addressed register bus with a single-cycle write strobe and combinational read data. Every register except the access key register ignores writes until a write-enable key has been written.

A request is made by writing the control register with its start bit set. In the synchronous mode the target policy becomes active at once, and the start bit stays set for a settle delay of `SETTLE_CYCLES` cycles. In the auto-copy mode the old policy stays active while the modelled settle delay runs. The target is then copied to the active policy on the cycle the start bit clears. The engine can also be halted with a stop bit. That bit stays high for `STOP_CYCLES` cycles and then clears. The mask registers accept writes only while the engine is halted, and a start request restarts the engine.

The engine is one state machine:
- States: `ST_RUN` (idle, running), `ST_SYNC`, `ST_ASYNC`, `ST_NOLOAD` (settling), `ST_STOPPING` and `ST_STOPPED`.
- From `ST_RUN` or `ST_STOPPED`, an accepted start goes to `ST_SYNC` if the sync bit is set. Otherwise it goes to `ST_ASYNC` if the auto-copy bit is set, and to `ST_NOLOAD` if neither is set.
- Each settle state returns to `ST_RUN` when its counter reaches zero.
- `ST_RUN` goes to `ST_STOPPING` on an accepted stop write.
- `ST_STOPPING` goes to `ST_STOPPED` when its counter reaches zero.

Top module: `power_policy_ctrl`

## Requirements
- R1: After reset the active and target policies are 2, the block is locked, the engine is in `ST_RUN`, every mask holds all ones and `clk_en` is all ones.
- R2: A write to address 0 whose bits [31:8] equal 0xA5A500 sets the unlock flag to bit 0 of the data. Address 0 reads back the flag in bit 0. Other writes to address 0 are ignored. While locked, writes to addresses 1 to 7 have no effect.
- R3: A control write (address 1) with bit 0 (start) and bit 1 (sync) set loads the target policy into `active_policy` at that write's clock edge. Bit 0 of address 1 then reads 1 for exactly `SETTLE_CYCLES` cycles and 0 afterwards.
- R4: A control write with bit 0 and bit 2 (auto-copy) set and bit 1 clear leaves `active_policy` unchanged while bit 0 reads 1. The target is copied on the same edge that clears bit 0.
- R5: A control write with only bit 0 set runs the settle delay and leaves `active_policy` unchanged.
- R6: A start write during a settle period, or while stopping, is ignored: the period neither restarts nor lengthens, and the mode bits do not change.
- R7: Address 1 reads bit 0 = busy, bits 1 and 2 = mode of the last accepted request, and all other bits 0. A control write without bit 0 changes no state.
- R8: Writing 1 to bit 0 of address 2 while in `ST_RUN` makes that bit read 1 for exactly `STOP_CYCLES` cycles and then 0, which leaves the engine stopped. The write is ignored in any other state.
- R9: Address 4+p holds the mask of policy p. Writes to it take effect only while stopped. A start request accepted while stopped restarts the engine.
- R10: `clk_en` equals the low `NUM_CLK` bits of the mask of the active policy. Each clock uses the same bit position in all four masks.
- R11: Address 3 bits [1:0] hold the target policy. A request uses the target as it stood when the request was accepted, so later target writes do not affect a request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| active_policy | output | 2 | Policy currently in effect |
| clk_en | output | NUM_CLK | Per-clock enables of the active policy |

## Verification
Every write takes effect at the clock edge that samples it:
- A synchronous load shows on `active_policy` right after that edge.
- The busy bit reads 1 after that edge and for `SETTLE_CYCLES` cycles in all. An auto-copy load appears `SETTLE_CYCLES` edges after the request.
- The stop bit clears `STOP_CYCLES` edges after the stop write.
- Mask and target writes, and the `clk_en` they drive, are visible one edge after the write.

The bench counts clock edges. It queues each expected `active_policy` and `clk_en` value tagged with the edge number at which it must hold, and compares between edges. Register reads are taken in the half cycle after a known edge, so each busy-bit and stop-bit sample lands on an exact cycle of its window.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

    localparam int NUM_POLICY = 4;
    localparam int POL_W      = 2;
    localparam logic [POL_W-1:0] BOOT_POLICY = 2'd2;

    // write-enable key expected in data bits [31:8]
    localparam logic [23:0] ACCESS_KEY = 24'hA5A500;

    // register word addresses
    localparam int A_KEY    = 0;
    localparam int A_CTRL   = 1;
    localparam int A_STOP   = 2;
    localparam int A_TARGET = 3;
    localparam int A_MASK0  = 4;

    // control register bit positions
    localparam int B_START = 0;
    localparam int B_SYNC  = 1;
    localparam int B_AUTO  = 2;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SYNC,
        ST_ASYNC,
        ST_NOLOAD,
        ST_STOPPING,
        ST_STOPPED
    } eng_state_e;

endpackage

// File: rtl/ppe_access_gate.sv
module ppe_access_gate
    import ppe_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              unlocked,
    output logic              go_req,
    output logic              req_sync,
    output logic              req_auto,
    output logic              stop_req,
    output logic              tgt_wr,
    output logic              mask_wr,
    output logic [POL_W-1:0]  mask_idx
);

    logic key_hit;
    logic wr_en;
    logic unused_bits;

    assign unused_bits = ^wdata[7:3];

    assign key_hit = wr && (addr == ADDR_W'(A_KEY)) && (wdata[31:8] == ACCESS_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            unlocked <= 1'b0;
        else if (key_hit)
            unlocked <= wdata[0];
    end

    assign wr_en    = wr && unlocked;
    assign go_req   = wr_en && (addr == ADDR_W'(A_CTRL)) && wdata[B_START];
    assign req_sync = wdata[B_SYNC];
    assign req_auto = wdata[B_AUTO];
    assign stop_req = wr_en && (addr == ADDR_W'(A_STOP)) && wdata[0];
    assign tgt_wr   = wr_en && (addr == ADDR_W'(A_TARGET));
    assign mask_wr  = wr_en && (addr >= ADDR_W'(A_MASK0))
                            && (addr <  ADDR_W'(A_MASK0 + NUM_POLICY));
    assign mask_idx = addr[POL_W-1:0];

endmodule

// File: rtl/ppe_engine_fsm.sv
module ppe_engine_fsm
    import ppe_pkg::*;
#(
    parameter int SETTLE_CYCLES = 8,
    parameter int STOP_CYCLES   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_req,
    input  logic             req_sync,
    input  logic             req_auto,
    input  logic             stop_req,
    input  logic [POL_W-1:0] target,
    output logic [POL_W-1:0] active_policy,
    output logic             busy,
    output logic             stopping,
    output logic             stopped,
    output logic             mode_sync,
    output logic             mode_auto
);

    localparam int MAX_WAIT = (SETTLE_CYCLES > STOP_CYCLES) ? SETTLE_CYCLES : STOP_CYCLES;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    eng_state_e        state, next_state;
    logic [CNT_W-1:0]  cnt;
    logic [POL_W-1:0]  lat_tgt;
    logic              go_ok;
    logic              stop_ok;
    eng_state_e        start_state;

    assign go_ok   = go_req && (state == ST_RUN || state == ST_STOPPED);
    assign stop_ok = stop_req && (state == ST_RUN);

    always_comb begin
        if (req_sync)
            start_state = ST_SYNC;
        else if (req_auto)
            start_state = ST_ASYNC;
        else
            start_state = ST_NOLOAD;
    end

    // next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            ST_RUN: begin
                if (go_ok)
                    next_state = start_state;
                else if (stop_ok)
                    next_state = ST_STOPPING;
            end
            ST_STOPPED: begin
                if (go_ok)
                    next_state = start_state;
            end
            ST_SYNC, ST_ASYNC, ST_NOLOAD: begin
                if (cnt == '0)
                    next_state = ST_RUN;
            end
            ST_STOPPING: begin
                if (cnt == '0)
                    next_state = ST_STOPPED;
            end
            default: next_state = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= next_state;
    end

    // datapath: wait counter, latched request, active policy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt           <= '0;
            lat_tgt       <= BOOT_POLICY;
            active_policy <= BOOT_POLICY;
            mode_sync     <= 1'b0;
            mode_auto     <= 1'b0;
        end else begin
            if (go_ok) begin
                cnt       <= CNT_W'(SETTLE_CYCLES - 1);
                lat_tgt   <= target;
                mode_sync <= req_sync;
                mode_auto <= req_auto;
                if (req_sync)
                    active_policy <= target;
            end else if (stop_ok) begin
                cnt <= CNT_W'(STOP_CYCLES - 1);
            end else if (cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
            end
            if (state == ST_ASYNC && cnt == '0)
                active_policy <= lat_tgt;
        end
    end

    // outputs
    always_comb begin
        busy     = (state == ST_SYNC) || (state == ST_ASYNC) || (state == ST_NOLOAD);
        stopping = (state == ST_STOPPING);
        stopped  = (state == ST_STOPPED);
    end

    assert_busy_go_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_req && cnt != '0) |=> (busy && cnt == $past(cnt) - CNT_W'(1)));

    assert_sync_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_ok && req_sync) |=> (active_policy == $past(target)));

    assert_async_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ASYNC && cnt != '0) |=> $stable(active_policy));

    assert_async_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ASYNC && cnt == '0) |=> (active_policy == $past(lat_tgt) && state == ST_RUN));

    assert_noload_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOLOAD) |=> $stable(active_policy));

    assert_stop_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOPPING && cnt == '0) |=> (state == ST_STOPPED));

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) < MAX_WAIT));

endmodule

// File: rtl/ppe_policy_regs.sv
module ppe_policy_regs
    import ppe_pkg::*;
#(
    parameter int          NUM_CLK   = 32,
    parameter logic [31:0] MASK_INIT = 32'hFFFF_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tgt_wr,
    input  logic               mask_wr,
    input  logic [POL_W-1:0]   mask_idx,
    input  logic [31:0]        wdata,
    input  logic               wr_ok,
    input  logic [POL_W-1:0]   active,
    input  logic [POL_W-1:0]   rd_idx,
    output logic [POL_W-1:0]   target,
    output logic [31:0]        mask_rd,
    output logic [NUM_CLK-1:0] clk_en
);

    logic [NUM_POLICY-1:0][31:0] mask_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            target <= BOOT_POLICY;
        else if (tgt_wr)
            target <= wdata[POL_W-1:0];
    end

    for (genvar p = 0; p < NUM_POLICY; p++) begin : g_pol
        logic [31:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= MASK_INIT;
            else if (mask_wr && wr_ok && mask_idx == POL_W'(p))
                q <= wdata;
        end
        assign mask_all[p] = q;
    end

    logic [31:0] act_mask;
    assign act_mask = mask_all[active];
    assign clk_en   = act_mask[NUM_CLK-1:0];
    assign mask_rd  = mask_all[rd_idx];

    assert_mask_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(mask_all));

    assert_target_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_wr |=> $stable(target));

endmodule

// File: rtl/power_policy_ctrl.sv
module power_policy_ctrl
    import ppe_pkg::*;
#(
    parameter int          ADDR_W        = 4,
    parameter int          NUM_CLK       = 32,
    parameter int          SETTLE_CYCLES = 8,
    parameter int          STOP_CYCLES   = 4,
    parameter logic [31:0] MASK_INIT     = 32'hFFFF_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [1:0]         active_policy,
    output logic [NUM_CLK-1:0] clk_en
);

    logic             unlocked;
    logic             go_req, req_sync, req_auto, stop_req;
    logic             tgt_wr, mask_wr;
    logic [POL_W-1:0] mask_idx;
    logic [POL_W-1:0] target;
    logic             busy, stopping, stopped, mode_sync, mode_auto;
    logic [31:0]      mask_rd;

    ppe_access_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .unlocked (unlocked),
        .go_req   (go_req),
        .req_sync (req_sync),
        .req_auto (req_auto),
        .stop_req (stop_req),
        .tgt_wr   (tgt_wr),
        .mask_wr  (mask_wr),
        .mask_idx (mask_idx)
    );

    ppe_engine_fsm #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .STOP_CYCLES   (STOP_CYCLES)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .go_req        (go_req),
        .req_sync      (req_sync),
        .req_auto      (req_auto),
        .stop_req      (stop_req),
        .target        (target),
        .active_policy (active_policy),
        .busy          (busy),
        .stopping      (stopping),
        .stopped       (stopped),
        .mode_sync     (mode_sync),
        .mode_auto     (mode_auto)
    );

    ppe_policy_regs #(
        .NUM_CLK   (NUM_CLK),
        .MASK_INIT (MASK_INIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt_wr   (tgt_wr),
        .mask_wr  (mask_wr),
        .mask_idx (mask_idx),
        .wdata    (bus_wdata),
        .wr_ok    (stopped),
        .active   (active_policy),
        .rd_idx   (bus_addr[POL_W-1:0]),
        .target   (target),
        .mask_rd  (mask_rd),
        .clk_en   (clk_en)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_KEY))
            bus_rdata = {31'b0, unlocked};
        else if (bus_addr == ADDR_W'(A_CTRL))
            bus_rdata = {29'b0, mode_auto, mode_sync, busy};
        else if (bus_addr == ADDR_W'(A_STOP))
            bus_rdata = {31'b0, stopping};
        else if (bus_addr == ADDR_W'(A_TARGET))
            bus_rdata = {30'b0, target};
        else if (bus_addr >= ADDR_W'(A_MASK0) && bus_addr < ADDR_W'(A_MASK0 + NUM_POLICY))
            bus_rdata = mask_rd;
    end

    assert_locked_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_wr && bus_addr == ADDR_W'(A_TARGET)) |=> $stable(target));

    assert_locked_engine_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && !busy && !stopping) |=> !busy || $past(unlocked));

endmodule

// File: tb/power_policy_ctrl_test.sv
module power_policy_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;
    localparam int STOP       = 3;
    localparam int NCLK       = 32;
    localparam int AW         = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [1:0]      active_policy;
    logic [NCLK-1:0] clk_en;

    power_policy_ctrl #(
        .ADDR_W        (AW),
        .NUM_CLK       (NCLK),
        .SETTLE_CYCLES (SETTLE),
        .STOP_CYCLES   (STOP)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .active_policy (active_policy),
        .clk_en        (clk_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          cyc;
        string       req;
        int          kind;   // 0: active_policy, 1: clk_en
        logic [31:0] exp;
    } item_t;

    item_t sbq[$];
    int    cyc    = 0;
    int    n_chk  = 0;
    int    n_fail = 0;
    int    last_e = 0;
    bit    done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int at, input string req, input int kind, input logic [31:0] exp);
        item_t it;
        it.cyc = at; it.req = req; it.kind = kind; it.exp = exp;
        sbq.push_back(it);
    endtask

    // monitor: compares queued expectations at their due cycle
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = (it.kind == 0) ? {30'b0, active_policy} : clk_en;
            if (it.cyc != cyc)
                check(it.req, "scoreboard item missed", 32'(cyc), 32'(it.cyc));
            else
                check(it.req, (it.kind == 0) ? "active_policy" : "clk_en", act, it.exp);
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        last_e = cyc;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int e;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1", "active after reset", {30'b0, active_policy}, 32'd2);
        check("R1", "clk_en after reset", clk_en, 32'hFFFF_FFFF);
        rd(3, d); check("R1", "target after reset", d, 32'd2);
        rd(0, d); check("R1", "locked after reset", d, 32'd0);
        rd(1, d); check("R1", "ctrl after reset", d, 32'd0);

        // R2 locked writes ignored
        wr(3, 32'd1);
        rd(3, d); check("R2", "target write while locked", d, 32'd2);
        wr(1, 32'h3);
        rd(1, d); check("R2", "start while locked", d, 32'd0);
        check("R2", "active after locked start", {30'b0, active_policy}, 32'd2);
        wr(0, 32'hA5A4_0001);
        rd(0, d); check("R2", "wrong key", d, 32'd0);
        wr(0, 32'hA5A5_0001);
        rd(0, d); check("R2", "right key", d, 32'd1);

        // R11 target register
        wr(3, 32'd3);
        rd(3, d); check("R11", "target readback", d, 32'd3);

        // R3 synchronous request
        wr(1, 32'h3);
        e = last_e;
        push(e, "R3", 0, 32'd3);
        rd(1, d); check("R3", "ctrl right after sync start", d, 32'h3);
        for (int k = 1; k <= SETTLE; k++) begin
            idle(1);
            rd(1, d);
            check("R3", "busy bit window", {31'b0, d[0]}, (k < SETTLE) ? 32'd1 : 32'd0);
        end
        check("R7", "ctrl mode after sync", d, 32'h2);

        // R4 auto-copy request, with R6 and R11 interference while busy
        wr(3, 32'd1);
        wr(1, 32'h5);
        e = last_e;
        push(e + SETTLE - 1, "R4", 0, 32'd3);
        push(e + SETTLE,     "R4", 0, 32'd1);
        push(e + SETTLE + 2, "R11", 0, 32'd1);
        idle(1);
        wr(3, 32'd0);
        wr(1, 32'h3);
        rd(1, d); check("R6", "start ignored while busy", d, 32'h5);
        idle(1);
        rd(1, d); check("R4", "busy clears on schedule", d, 32'h4);
        idle(2);
        rd(3, d); check("R11", "target written during busy", d, 32'd0);

        // R5 request with no load transfer
        wr(1, 32'h1);
        e = last_e;
        push(e + SETTLE, "R5", 0, 32'd1);
        idle(SETTLE + 1);
        rd(1, d); check("R5", "no-load request done", d, 32'd0);

        // R9 mask write while running ignored
        wr(4, 32'h0);
        rd(4, d); check("R9", "mask write while running", d, 32'hFFFF_FFFF);

        // R8 stop sequence
        wr(2, 32'h1);
        rd(2, d); check("R8", "stop bit right after write", d, 32'd1);
        for (int k = 1; k <= STOP; k++) begin
            idle(1);
            rd(2, d);
            check("R8", "stop bit window", d, (k < STOP) ? 32'd1 : 32'd0);
        end

        // R9 masks writable while stopped; R10 enables follow active policy 1
        wr(4, 32'h0000_00F0);
        wr(5, 32'h0000_0F0F);
        wr(6, 32'hFFFF_0000);
        wr(7, 32'h1234_5678);
        rd(4, d); check("R9", "mask p0", d, 32'h0000_00F0);
        rd(5, d); check("R9", "mask p1", d, 32'h0000_0F0F);
        rd(6, d); check("R9", "mask p2", d, 32'hFFFF_0000);
        rd(7, d); check("R9", "mask p3", d, 32'h1234_5678);
        check("R10", "clk_en for policy 1", clk_en, 32'h0000_0F0F);

        // R8 stop while stopped ignored
        wr(2, 32'h1);
        rd(2, d); check("R8", "stop while stopped", d, 32'd0);

        // R9 restart from stopped with sync request to policy 3
        wr(3, 32'd3);
        wr(1, 32'h3);
        e = last_e;
        push(e, "R9", 0, 32'd3);
        push(e, "R10", 1, 32'h1234_5678);
        idle(SETTLE + 1);
        wr(7, 32'h0);
        rd(7, d); check("R9", "mask write after restart", d, 32'h1234_5678);

        // R7 full control write without start
        wr(1, 32'hFFFF_FFF8);
        rd(1, d); check("R7", "ctrl after write without start", d, 32'h2);
        rd(3, d); check("R7", "target untouched by ctrl write", d, 32'd3);

        // R2 relock
        wr(0, 32'hA5A5_0000);
        rd(0, d); check("R2", "relock", d, 32'd0);
        wr(3, 32'd1);
        rd(3, d); check("R2", "target write after relock", d, 32'd3);

        idle(3);
        if (sbq.size() != 0)
            check("R1", "scoreboard drained", 32'(sbq.size()), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule